// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block sequences the operating state of a serial peripheral core and collects its status. Software writes a state request over a simple single-cycle register bus. The sequencer moves the core between reset, run and pause. A valid bit in the state register shows when the state is stable. Leaving pause for reset needs a two-step clear sequence, so one stray write cannot throw away a paused transfer. A software-reset register forces the block back to reset at once.

The data path is outside this block. It appears only as single-cycle event inputs: service and done events, four FIFO error events, two serial-clock error events, and a word-completed strobe. The block latches these into sticky write-1-to-clear flag registers, each paired with a per-bit enable or mask register. It counts completed words and drives a level-high interrupt.

The sequencer has five states:
- `F_RESET`, `F_RUN` and `F_PAUSE` are the three steady states.
- `F_PAUSE_ARMED` is pause with the first clear write remembered.
- `F_SETTLE` is the timed transition in which valid is low.

The transitions are:
- A request from any steady state goes to `F_SETTLE`.
- `F_PAUSE` goes to `F_PAUSE_ARMED` on a clear write.
- `F_PAUSE_ARMED` goes to `F_SETTLE` (towards reset) on a second clear write, and back to `F_PAUSE` on a write of 0.
- `F_SETTLE` goes to the target steady state when its counter expires.
- A software reset goes from any state to `F_RESET`.

Top module: `rsc_run_ctrl`

## Requirements
- R1: The state register (address 0) reads the current state in bits [1:0], encoded reset = 0, run = 1, pause = 3, and a read-only valid flag in bit 2. After power-on reset it reads 0x4 (reset, valid).
- R2: A state write is accepted only while valid is 1. For an accepted write, valid reads 0 for exactly SETTLE_CYC cycles (default 4). During that time the old state stays visible. When valid returns to 1, the new state is visible. State writes made while valid is 0 are ignored.
- R3: In pause, a write of 0 is ignored. Pause moves to reset only after two state writes of 2 with no other state write between them. A write of 2 in run or reset is ignored.
- R4: In pause, a state write of any value other than 2 cancels a remembered first write of 2. Example: the sequence 2, 0, 2 leaves the block in pause with valid 1.
- R5: Writing a value with bit 0 set to the software-reset register (address 1) puts the block in reset with valid 1 at the next cycle. It also clears every flag, enable, mask and the word counter. A write with bit 0 clear has no effect.
- R6: The FIFO error register (address 4) latches four events into sticky bits. Input err_evt_i[0] (input overrun) sets bit 2, err_evt_i[1] (output underrun) sets bit 3, err_evt_i[2] (input underrun) sets bit 4 and err_evt_i[3] (output overrun) sets bit 5. Writing 1 to a bit clears it, and an event in the same cycle wins. Address 5 holds per-bit enables with the same layout.
- R7: The serial error register (address 6) latches clock overrun (serr_evt_i[1]) in bit 1 and clock underrun (serr_evt_i[0]) in bit 0, with write-1-to-clear. Address 7 holds their enables.
- R8: The operational register (address 2) latches op_evt_i[3:0] in bits [3:0]: input service, output service, input done, output done. It uses write-1-to-clear. Address 3 is a mask, where 1 stops a bit from raising the interrupt.
- R9: While the visible state is reset, event inputs set no flag and word strobes are not counted.
- R10: The word counter (address 8) increments by one for each word_evt_i cycle while the visible state is run.
- R11: Completing a transition into reset clears all flags and the word counter. Enables and masks keep their values.
- R12: irq_o is high exactly when some error flag has its enable set, or some operational flag is unmasked. It follows a flag change with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address for reads and writes |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| op_evt_i | input | 4 | Service and done events |
| err_evt_i | input | 4 | FIFO error events |
| serr_evt_i | input | 2 | Serial clock error events |
| word_evt_i | input | 1 | One word completed |
| irq_o | output | 1 | Level interrupt |

## Verification
A write, an event pulse or a software reset takes effect at the single rising edge during which it is driven. Register readback is combinational, so every register result is due one cycle after its stimulus, and irq_o is due at the same time. The exception is a state request. Its valid bit falls one cycle after the write and rises again SETTLE_CYC cycles after that, when the new state code appears. To keep to this timing, the bench drives every input on the falling edge. It samples a fixed short delay after a falling edge, and counts the low-valid samples cycle by cycle rather than waiting on an arbitrary delay.

// File: rtl/rsc_pkg.sv
`timescale 1ns/100ps
package rsc_pkg;

    // Architectural state codes seen in bits [1:0] of the state register.
    typedef enum logic [1:0] {
        RS_RESET = 2'd0,
        RS_RUN   = 2'd1,
        RS_CLEAR = 2'd2,
        RS_PAUSE = 2'd3
    } run_code_e;

    // Internal sequencer states.
    typedef enum logic [2:0] {
        F_RESET,
        F_RUN,
        F_PAUSE,
        F_PAUSE_ARMED,
        F_SETTLE
    } fsm_e;

    // Register word addresses.
    localparam int unsigned A_STATE  = 0;
    localparam int unsigned A_SOFT   = 1;
    localparam int unsigned A_OP     = 2;
    localparam int unsigned A_OPMASK = 3;
    localparam int unsigned A_ERR    = 4;
    localparam int unsigned A_ERREN  = 5;
    localparam int unsigned A_SERR   = 6;
    localparam int unsigned A_SERREN = 7;
    localparam int unsigned A_WCNT   = 8;

    localparam int unsigned OP_W    = 4;
    localparam int unsigned ERR_W   = 4;
    localparam int unsigned ERR_LSB = 2;
    localparam int unsigned SERR_W  = 2;

endpackage

// File: rtl/rsc_state_fsm.sv
`timescale 1ns/100ps
module rsc_state_fsm
    import rsc_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       soft_rst_i,
    input  logic       req_wr_i,
    input  logic [1:0] req_code_i,
    output run_code_e  state_o,
    output logic       valid_o,
    output logic       enter_reset_o
);

    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC - 1);

    fsm_e           fsm_q, fsm_d;
    run_code_e      tgt_q, tgt_d;
    run_code_e      src_q, src_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    run_code_e      shown;
    logic           go;
    run_code_e      go_tgt;

    function automatic fsm_e steady_of(run_code_e c);
        case (c)
            RS_RUN:   return F_RUN;
            RS_PAUSE: return F_PAUSE;
            default:  return F_RESET;
        endcase
    endfunction

    // Output process: visible code, valid flag, reset-entry pulse.
    always_comb begin
        unique case (fsm_q)
            F_RESET:                shown = RS_RESET;
            F_RUN:                  shown = RS_RUN;
            F_PAUSE, F_PAUSE_ARMED: shown = RS_PAUSE;
            F_SETTLE:               shown = src_q;
            default:                shown = RS_RESET;
        endcase
        state_o       = shown;
        valid_o       = (fsm_q != F_SETTLE);
        enter_reset_o = soft_rst_i ||
                        ((fsm_q == F_SETTLE) && (cnt_q == '0) && (tgt_q == RS_RESET));
    end

    // Next-state logic.
    always_comb begin
        fsm_d  = fsm_q;
        tgt_d  = tgt_q;
        src_d  = src_q;
        cnt_d  = cnt_q;
        go     = 1'b0;
        go_tgt = RS_RESET;
        unique case (fsm_q)
            F_RESET, F_RUN: begin
                if (req_wr_i && (req_code_i != RS_CLEAR)) begin
                    go     = 1'b1;
                    go_tgt = run_code_e'(req_code_i);
                end
            end
            F_PAUSE: begin
                if (req_wr_i) begin
                    if (req_code_i == RS_CLEAR) begin
                        fsm_d = F_PAUSE_ARMED;
                    end else if (req_code_i != RS_RESET) begin
                        go     = 1'b1;
                        go_tgt = run_code_e'(req_code_i);
                    end
                end
            end
            F_PAUSE_ARMED: begin
                if (req_wr_i) begin
                    if (req_code_i == RS_CLEAR) begin
                        go     = 1'b1;
                        go_tgt = RS_RESET;
                    end else if (req_code_i == RS_RESET) begin
                        fsm_d = F_PAUSE;
                    end else begin
                        go     = 1'b1;
                        go_tgt = run_code_e'(req_code_i);
                    end
                end
            end
            F_SETTLE: begin
                if (cnt_q == '0) begin
                    fsm_d = steady_of(tgt_q);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: fsm_d = F_RESET;
        endcase
        if (go) begin
            fsm_d = F_SETTLE;
            tgt_d = go_tgt;
            src_d = shown;
            cnt_d = CNT_LOAD;
        end
        if (soft_rst_i) begin
            fsm_d = F_RESET;
            cnt_d = '0;
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= F_RESET;
            tgt_q <= RS_RESET;
            src_q <= RS_RESET;
            cnt_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            tgt_q <= tgt_d;
            src_q <= src_d;
            cnt_q <= cnt_d;
        end
    end

    assert_code_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o != RS_CLEAR);

    assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_o && !soft_rst_i) |=> (valid_o || $stable(state_o)));

    assert_settle_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q == F_SETTLE) |-> (cnt_q <= CNT_LOAD));

    assert_pause_zero_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q == F_PAUSE && req_wr_i && req_code_i == RS_RESET && !soft_rst_i)
        |=> (valid_o && state_o == RS_PAUSE));

    assert_armed_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q == F_PAUSE_ARMED && req_wr_i && req_code_i == RS_RESET && !soft_rst_i)
        |=> (fsm_q == F_PAUSE));

    assert_soft_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (state_o == RS_RESET && valid_o));

endmodule

// File: rtl/rsc_flag_bank.sv
`timescale 1ns/100ps
module rsc_flag_bank #(
    parameter int unsigned W        = 4,
    parameter bit          MASK_POL = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         soft_clr_i,
    input  logic         flag_clr_i,
    input  logic         capture_i,
    input  logic [W-1:0] evt_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_bits_i,
    input  logic         sel_wr_i,
    input  logic [W-1:0] sel_wdata_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] sel_o,
    output logic         hit_o
);

    logic [W-1:0] flags_q;
    logic [W-1:0] sel_q;
    logic [W-1:0] active;
    logic [W-1:0] clr_v;
    logic [W-1:0] set_v;

    assign clr_v = clr_wr_i  ? clr_bits_i : '0;
    assign set_v = capture_i ? evt_i      : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else if (soft_clr_i || flag_clr_i) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_v) | set_v;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else if (soft_clr_i) begin
            sel_q <= '0;
        end else if (sel_wr_i) begin
            sel_q <= sel_wdata_i;
        end
    end

    generate
        if (MASK_POL) begin : g_mask
            assign active = ~sel_q;
        end else begin : g_enable
            assign active = sel_q;
        end
    endgenerate

    assign hit_o   = |(flags_q & active);
    assign flags_o = flags_q;
    assign sel_o   = sel_q;

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!soft_clr_i && !flag_clr_i && !clr_wr_i)
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_idle_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture_i |=> ((flags_q & ~$past(flags_q)) == '0));

    assert_reset_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_clr_i |=> (flags_q == '0));

endmodule

// File: rtl/rsc_word_counter.sv
`timescale 1ns/100ps
module rsc_word_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    assert_count_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !inc_i) |=> $stable(cnt_q));

    assert_count_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rsc_run_ctrl.sv
`timescale 1ns/100ps
module rsc_run_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned CNT_W      = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [3:0]        op_evt_i,
    input  logic [3:0]        err_evt_i,
    input  logic [1:0]        serr_evt_i,
    input  logic              word_evt_i,
    output logic              irq_o
);

    localparam int unsigned ERR_MSB = ERR_LSB + ERR_W - 1;

    logic wr_state, wr_soft, wr_op, wr_opmask, wr_err, wr_erren, wr_serr, wr_serren;
    logic soft_rst, enter_reset, capture, valid;
    run_code_e state;

    logic [OP_W-1:0]   op_flags, op_mask;
    logic [ERR_W-1:0]  err_flags, err_en;
    logic [SERR_W-1:0] serr_flags, serr_en;
    logic              op_hit, err_hit, serr_hit;
    logic [CNT_W-1:0]  wcnt;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
        return a == ADDR_W'(r);
    endfunction

    assign wr_state  = bus_wr_i && hit(bus_addr_i, A_STATE);
    assign wr_soft   = bus_wr_i && hit(bus_addr_i, A_SOFT);
    assign wr_op     = bus_wr_i && hit(bus_addr_i, A_OP);
    assign wr_opmask = bus_wr_i && hit(bus_addr_i, A_OPMASK);
    assign wr_err    = bus_wr_i && hit(bus_addr_i, A_ERR);
    assign wr_erren  = bus_wr_i && hit(bus_addr_i, A_ERREN);
    assign wr_serr   = bus_wr_i && hit(bus_addr_i, A_SERR);
    assign wr_serren = bus_wr_i && hit(bus_addr_i, A_SERREN);

    assign soft_rst = wr_soft && bus_wdata_i[0];
    assign capture  = (state != RS_RESET);

    rsc_state_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .soft_rst_i   (soft_rst),
        .req_wr_i     (wr_state),
        .req_code_i   (bus_wdata_i[1:0]),
        .state_o      (state),
        .valid_o      (valid),
        .enter_reset_o(enter_reset)
    );

    rsc_flag_bank #(.W(OP_W), .MASK_POL(1'b1)) u_op_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_clr_i (soft_rst),
        .flag_clr_i (enter_reset),
        .capture_i  (capture),
        .evt_i      (op_evt_i),
        .clr_wr_i   (wr_op),
        .clr_bits_i (bus_wdata_i[OP_W-1:0]),
        .sel_wr_i   (wr_opmask),
        .sel_wdata_i(bus_wdata_i[OP_W-1:0]),
        .flags_o    (op_flags),
        .sel_o      (op_mask),
        .hit_o      (op_hit)
    );

    rsc_flag_bank #(.W(ERR_W), .MASK_POL(1'b0)) u_err_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_clr_i (soft_rst),
        .flag_clr_i (enter_reset),
        .capture_i  (capture),
        .evt_i      (err_evt_i),
        .clr_wr_i   (wr_err),
        .clr_bits_i (bus_wdata_i[ERR_MSB:ERR_LSB]),
        .sel_wr_i   (wr_erren),
        .sel_wdata_i(bus_wdata_i[ERR_MSB:ERR_LSB]),
        .flags_o    (err_flags),
        .sel_o      (err_en),
        .hit_o      (err_hit)
    );

    rsc_flag_bank #(.W(SERR_W), .MASK_POL(1'b0)) u_serr_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_clr_i (soft_rst),
        .flag_clr_i (enter_reset),
        .capture_i  (capture),
        .evt_i      (serr_evt_i),
        .clr_wr_i   (wr_serr),
        .clr_bits_i (bus_wdata_i[SERR_W-1:0]),
        .sel_wr_i   (wr_serren),
        .sel_wdata_i(bus_wdata_i[SERR_W-1:0]),
        .flags_o    (serr_flags),
        .sel_o      (serr_en),
        .hit_o      (serr_hit)
    );

    rsc_word_counter #(.CNT_W(CNT_W)) u_wcnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (enter_reset),
        .inc_i  (word_evt_i && (state == RS_RUN)),
        .count_o(wcnt)
    );

    assign irq_o = op_hit || err_hit || serr_hit;

    // Combinational readback.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            ADDR_W'(A_STATE): begin
                bus_rdata_o[1:0] = state;
                bus_rdata_o[2]   = valid;
            end
            ADDR_W'(A_OP):     bus_rdata_o[OP_W-1:0]          = op_flags;
            ADDR_W'(A_OPMASK): bus_rdata_o[OP_W-1:0]          = op_mask;
            ADDR_W'(A_ERR):    bus_rdata_o[ERR_MSB:ERR_LSB]   = err_flags;
            ADDR_W'(A_ERREN):  bus_rdata_o[ERR_MSB:ERR_LSB]   = err_en;
            ADDR_W'(A_SERR):   bus_rdata_o[SERR_W-1:0]        = serr_flags;
            ADDR_W'(A_SERREN): bus_rdata_o[SERR_W-1:0]        = serr_en;
            ADDR_W'(A_WCNT):   bus_rdata_o[CNT_W-1:0]         = wcnt;
            default:           bus_rdata_o                    = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata_i;

    assert_irq_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !bus_wr_i && !enter_reset) |=> irq_o);

    assert_reset_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == RS_RESET && valid && !bus_wr_i) |=> !irq_o);

endmodule

// File: tb/rsc_run_ctrl_bench.sv
`timescale 1ns/100ps
module rsc_run_ctrl_bench;

    localparam int AS = 0, ASOFT = 1, AOP = 2, AOPM = 3, AERR = 4, AEE = 5,
                   ASE = 6, ASEE = 7, AWC = 8;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  op_evt = '0;
    logic [3:0]  err_evt = '0;
    logic [1:0]  serr_evt = '0;
    logic        word_evt = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rsc_run_ctrl u_rsc_run_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_wr_i   (bus_wr),
        .bus_addr_i (bus_addr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .op_evt_i   (op_evt),
        .err_evt_i  (err_evt),
        .serr_evt_i (serr_evt),
        .word_evt_i (word_evt),
        .irq_o      (irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = a[3:0];
        #0.2;
        d = bus_rdata;
    endtask

    task automatic wait_valid(output int lows);
        logic [31:0] d;
        lows = 0;
        for (int i = 0; i < 50; i++) begin
            rd(AS, d);
            if (d[2]) break;
            lows++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [3:0] op, input logic [3:0] er,
                         input logic [1:0] se, input logic w);
        @(negedge clk);
        op_evt = op; err_evt = er; serr_evt = se; word_evt = w;
        @(negedge clk);
        op_evt = '0; err_evt = '0; serr_evt = '0; word_evt = 1'b0;
    endtask

    task automatic goto(input int code);
        int n;
        wr(AS, code);
        wait_valid(n);
    endtask

    function automatic logic exp_irq(logic [31:0] e, logic [31:0] ee, logic [31:0] s,
                                     logic [31:0] se, logic [31:0] o, logic [31:0] om);
        return (|(e & ee)) || (|(s & se)) || (|(o & ~om & 32'hF));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        logic [31:0] m_err, m_serr, m_op, m_cnt, ee, se, om;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(AS, d);   chk("R1", "reset state", d, 32'h4);
        chk("R12", "reset irq", {31'b0, irq}, 32'h0);
        rd(AERR, d); chk("R1", "reset err", d, 32'h0);

        // R2 settle length and new state
        wr(AS, 1);
        wait_valid(n);
        chk("R2", "valid low cycles", n, SETTLE);
        rd(AS, d); chk("R1", "run code", d, 32'h5);

        // R2 old state visible, busy write ignored
        wr(AS, 3);
        rd(AS, d); chk("R2", "old state while busy", d, 32'h1);
        wr(AS, 1);
        wait_valid(n);
        rd(AS, d); chk("R2", "busy write ignored", d, 32'h7);

        // R3 pause to reset sequence
        wr(AS, 0);
        rd(AS, d); chk("R3", "zero in pause ignored", d, 32'h7);
        wr(AS, 2);
        rd(AS, d); chk("R3", "first clear holds", d, 32'h7);
        wr(AS, 2);
        rd(AS, d); chk("R3", "second clear starts", d, 32'h3);
        wait_valid(n);
        rd(AS, d); chk("R3", "reached reset", d, 32'h4);
        goto(1);
        wr(AS, 2);
        rd(AS, d); chk("R3", "clear in run ignored", d, 32'h5);

        // R4 cancel of a half sequence
        goto(3);
        wr(AS, 2); wr(AS, 0); wr(AS, 2);
        rd(AS, d); chk("R4", "2,0,2 stays pause", d, 32'h7);
        wr(AS, 2);
        wait_valid(n);
        rd(AS, d); chk("R4", "completed after cancel", d, 32'h4);

        // R9 events in reset ignored
        wr(AEE, 32'h3C);
        pulse(4'hF, 4'hF, 2'h3, 1'b1);
        rd(AERR, d); chk("R9", "err in reset", d, 32'h0);
        rd(AOP, d);  chk("R9", "op in reset", d, 32'h0);
        rd(AWC, d);  chk("R9", "count in reset", d, 32'h0);
        chk("R9", "irq in reset", {31'b0, irq}, 32'h0);

        // R10, R6, R11
        goto(1);
        pulse('0, '0, '0, 1'b1); pulse('0, '0, '0, 1'b1); pulse('0, '0, '0, 1'b1);
        rd(AWC, d);  chk("R10", "word count", d, 32'h3);
        pulse('0, 4'b0001, '0, 1'b0);
        rd(AERR, d); chk("R6", "in overrun bit2", d, 32'h4);
        chk("R12", "enabled error irq", {31'b0, irq}, 32'h1);
        goto(0);
        rd(AERR, d); chk("R11", "flags cleared", d, 32'h0);
        rd(AWC, d);  chk("R11", "count cleared", d, 32'h0);
        rd(AEE, d);  chk("R11", "enables kept", d, 32'h3C);
        chk("R11", "irq after reset", {31'b0, irq}, 32'h0);

        // R12 timing and enables, R6 W1C
        goto(1);
        wr(AEE, 32'h20);
        pulse('0, 4'b0001, '0, 1'b0);
        chk("R12", "disabled flag no irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        err_evt = 4'b1000;
        #0.2 chk("R12", "irq not before edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        err_evt = '0;
        #0.2 chk("R12", "irq one cycle later", {31'b0, irq}, 32'h1);
        rd(AERR, d); chk("R6", "two flags", d, 32'h24);
        wr(AERR, 32'h20);
        rd(AERR, d); chk("R6", "w1c one bit", d, 32'h4);
        chk("R12", "irq dropped", {31'b0, irq}, 32'h0);

        // R8 op mask
        wr(AOPM, 32'hF);
        pulse(4'b0010, '0, '0, 1'b0);
        rd(AOP, d); chk("R8", "op latched", d, 32'h2);
        chk("R8", "masked no irq", {31'b0, irq}, 32'h0);
        wr(AOPM, 32'h0);
        chk("R8", "unmasked irq", {31'b0, irq}, 32'h1);
        wr(AOP, 32'h2);
        rd(AOP, d); chk("R8", "op w1c", d, 32'h0);
        chk("R8", "irq after op clear", {31'b0, irq}, 32'h0);

        // R7 serial errors
        wr(ASEE, 32'h3);
        pulse('0, '0, 2'b10, 1'b0);
        rd(ASE, d); chk("R7", "clock overrun bit1", d, 32'h2);
        chk("R7", "serial irq", {31'b0, irq}, 32'h1);
        wr(ASE, 32'h2);
        rd(ASE, d); chk("R7", "serial w1c", d, 32'h0);

        // R5 software reset
        wr(ASOFT, 32'h0);
        rd(AS, d); chk("R5", "bit0 clear no effect", d, 32'h5);
        wr(ASOFT, 32'h1);
        rd(AS, d);   chk("R5", "soft reset state", d, 32'h4);
        rd(AERR, d); chk("R5", "soft reset flags", d, 32'h0);
        rd(AEE, d);  chk("R5", "soft reset enables", d, 32'h0);
        rd(ASEE, d); chk("R5", "soft reset serial enables", d, 32'h0);

        // Random stimulus against a model: R6 R7 R8 R10 R12
        goto(1);
        ee = $urandom & 32'h3C; se = $urandom & 32'h3; om = $urandom & 32'hF;
        wr(AEE, ee); wr(ASEE, se); wr(AOPM, om);
        m_err = 0; m_serr = 0; m_op = 0; m_cnt = 0;
        for (int it = 0; it < 400; it++) begin
            logic [3:0] eo, ev;
            logic [1:0] sv;
            logic       wv;
            int         k;
            logic [31:0] cv;
            @(negedge clk);
            bus_wr = 1'b0;
            op_evt = '0; err_evt = '0; serr_evt = '0; word_evt = 1'b0;
            chk("R12", "random irq", {31'b0, irq},
                {31'b0, exp_irq(m_err, ee, m_serr, se, m_op, om)});
            rd(AERR, d); chk("R6", "random err", d, m_err);
            rd(ASE, d);  chk("R7", "random serial", d, m_serr);
            rd(AOP, d);  chk("R8", "random op", d, m_op);
            rd(AWC, d);  chk("R10", "random count", d, m_cnt);
            eo = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            ev = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            sv = ($urandom % 5 == 0) ? 2'($urandom) : 2'h0;
            wv = 1'($urandom);
            k  = $urandom % 6;
            cv = $urandom;
            op_evt = eo; err_evt = ev; serr_evt = sv; word_evt = wv;
            m_cnt = (m_cnt + wv) & 32'hFFFF;
            if (k == 0) begin
                bus_wr = 1'b1; bus_addr = AERR; bus_wdata = cv;
                m_err = m_err & ~(cv & 32'h3C);
            end else if (k == 1) begin
                bus_wr = 1'b1; bus_addr = ASE; bus_wdata = cv;
                m_serr = m_serr & ~(cv & 32'h3);
            end else if (k == 2) begin
                bus_wr = 1'b1; bus_addr = AOP; bus_wdata = cv;
                m_op = m_op & ~(cv & 32'hF);
            end
            m_err  = m_err  | {26'b0, ev, 2'b0};
            m_serr = m_serr | {30'b0, sv};
            m_op   = m_op   | {28'b0, eo};
        end
        @(negedge clk);
        bus_wr = 1'b0;
        op_evt = '0; err_evt = '0; serr_evt = '0; word_evt = 1'b0;
        chk("R12", "final irq", {31'b0, irq},
            {31'b0, exp_irq(m_err, ee, m_serr, se, m_op, om)});
        rd(AWC, d); chk("R10", "final count", d, m_cnt);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule